// File: doc/BRIEF.md
# GPIO Port Controller with Alternate-Function Overrides

The block holds three 8-bit general-purpose I/O ports behind a small register bus. Each pin has its own direction bit and a data bit. A read of a port's data register returns the synchronized pad level for pins that are not driven, and the stored value for pins that are driven. A write sets the value that driven pins put on the pad.

Alternate-function enables take priority over the direction bits. Some of them hand a pin to an internal source: two PWM channels, a DC/DC sync, a frame sync and a bit clock. Others force a pin to be an input that feeds a timer trigger or the 8 kHz master transmit clock. A test input remaps two pins, and this remap takes priority over every other setting. Writing a self-clearing control bit resets the whole block, with the same effect as the global reset.

The pads are flattened as pin index = port × 8 + bit. Each pin has three outputs: an output-enable, the value driven onto the pad, and the alternate source value.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register reads 0, and every output-enable, pad value, trigger, clock and test output is 0.
- R2: With no override active, `pin_oe_o[i]` equals direction bit i and `pin_do_o[i]` equals data bit i. The direction registers are at addresses 0, 1 and 2, one for each port.
- R3: The data registers are at addresses 3, 4 and 5. A read returns the stored data bit where the output-enable is 1, and the synchronized pad level where it is 0.
- R4: Address 6 bits 7:4 enable the alternate outputs on port 0 bits 7:4. Bits 7:6 of the port carry `pwm1_i` and bits 5:4 carry `pwm0_i`. Each enabled pin has output-enable 1.
- R5: Address 7 bits 7:5 force port 1 bits 7:5 to be inputs, whatever their direction bits say. `timer_trig_o[k]` is the synchronized level of port 1 bit 5+k while the enable is set, and 0 otherwise.
- R6: Address 7 bits 3:1 drive port 2 bits 3:1 as outputs. Bit 3 carries `dcsync_i`, bit 2 carries `fsync_i` and bit 1 carries `bclk_i`.
- R7: Address 8 bit 0 forces port 2 bit 6 to be an input. While that bit is set, `mtc_o` is its synchronized level.
- R8: While `test_mode_i` is 1, port 1 bit 4 is an input whose synchronized level appears on `test_sel_o`, and port 2 bit 7 is an output driven by `test_drv_i`. This holds over every other setting.
- R9: A write to address 7 with bit 0 set returns all registers and synchronizers to their reset state at that clock edge. Bit 0 of address 7 always reads 0.
- R10: All control registers read back as written. Unused bits (address 6 bits 3:0, address 7 bit 4, address 8 bits 7:1) and unused addresses read 0.
- R11: `pin_alt_o[i]` is 0 on every pin without an active alternate or test output, and equals the source on pins that have one.
- R12: A pad level reaches readback and the trigger outputs exactly two clock cycles after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pin_i | input | 24 | Pad input levels |
| pin_oe_o | output | 24 | Per-pin output-enable |
| pin_do_o | output | 24 | Per-pin pad drive value |
| pin_alt_o | output | 24 | Per-pin alternate source value, 0 where inactive |
| pwm0_i | input | 1 | PWM channel 0 source |
| pwm1_i | input | 1 | PWM channel 1 source |
| dcsync_i | input | 1 | DC/DC sync source |
| fsync_i | input | 1 | Frame sync source |
| bclk_i | input | 1 | Bit clock source |
| test_mode_i | input | 1 | Test remap enable |
| test_drv_i | input | 1 | Test drive value for port 2 bit 7 |
| timer_trig_o | output | 3 | Timer trigger inputs 2..0 |
| mtc_o | output | 1 | Master transmit clock input |
| test_sel_o | output | 1 | Test select input from port 1 bit 4 |

## Verification
The bench targets the priority chain. A forced-input override has to win over a set direction bit, so a design that got this wrong would drive the trigger or clock pin and read back the stored data instead of the pad. The test remap has to win over both kinds of override, so a wrong design would leave port 2 bit 7 undriven or keep port 1 bit 4 as an output. The bench counts clock edges to catch a synchronizer that is one stage too short or too long. It also checks that a soft reset clears the synchronizers as well as the registers; a design that missed this would return stale pad levels right after the reset. Finally, it checks that the reset bit and the reserved bits read as 0.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  // register addresses
  localparam logic [3:0] A_DIR0 = 4'd0;
  localparam logic [3:0] A_DAT0 = 4'd3;
  localparam logic [3:0] A_ALTA = 4'd6;
  localparam logic [3:0] A_ALTB = 4'd7;
  localparam logic [3:0] A_MODE = 4'd8;

  // priority: test output > test/forced input > alternate output > direction
  function automatic logic pin_oe_f(logic dir_b, logic alt_out_b, logic force_in_b,
                                    logic tst_in_b, logic tst_out_b);
    if (tst_out_b) return 1'b1;
    if (tst_in_b || force_in_b) return 1'b0;
    if (alt_out_b) return 1'b1;
    return dir_b;
  endfunction

  // readback: driven pins show stored data, the rest show the synchronized pad
  function automatic logic read_bit_f(logic oe_b, logic dat_b, logic sync_b);
    return oe_b ? dat_b : sync_b;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else if (clr) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ctrl_pkg::*;
#(
  parameter int PW    = 8,
  parameter int NPORT = 3,
  localparam int DW   = PW * NPORT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [PW-1:0] wdata,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] dat_q,
  output logic [3:0]    pwm_en_q,
  output logic [2:0]    trig_en_q,
  output logic [2:0]    p2_en_q,
  output logic          mode_q,
  output logic          srst_o
);
  // soft reset: non-latching, a one-cycle pulse on the write itself
  assign srst_o = wr_en && (addr == A_ALTB) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      dat_q     <= '0;
      pwm_en_q  <= '0;
      trig_en_q <= '0;
      p2_en_q   <= '0;
      mode_q    <= 1'b0;
    end else if (srst_o) begin
      dir_q     <= '0;
      dat_q     <= '0;
      pwm_en_q  <= '0;
      trig_en_q <= '0;
      p2_en_q   <= '0;
      mode_q    <= 1'b0;
    end else if (wr_en) begin
      for (int p = 0; p < NPORT; p++) begin
        if (addr == A_DIR0 + 4'(p)) dir_q[p*PW +: PW] <= wdata;
        if (addr == A_DAT0 + 4'(p)) dat_q[p*PW +: PW] <= wdata;
      end
      if (addr == A_ALTA) pwm_en_q <= wdata[7:4];
      if (addr == A_ALTB) begin
        trig_en_q <= wdata[7:5];
        p2_en_q   <= wdata[3:1];
      end
      if (addr == A_MODE) mode_q <= wdata[0];
    end
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_ctrl_pkg::*;
#(
  parameter int PW    = 8,
  parameter int NPORT = 3,
  localparam int DW   = PW * NPORT
) (
  input  logic [DW-1:0] dir_q,
  input  logic [DW-1:0] dat_q,
  input  logic [3:0]    pwm_en_q,
  input  logic [2:0]    trig_en_q,
  input  logic [2:0]    p2_en_q,
  input  logic          mode_q,
  input  logic          test_mode_i,
  input  logic          test_drv_i,
  input  logic          pwm0_i,
  input  logic          pwm1_i,
  input  logic          dcsync_i,
  input  logic          fsync_i,
  input  logic          bclk_i,
  output logic [DW-1:0] pin_oe_o,
  output logic [DW-1:0] pin_do_o,
  output logic [DW-1:0] pin_alt_o,
  output logic [DW-1:0] alt_act_o
);
  localparam int P1 = PW;
  localparam int P2 = 2 * PW;

  logic [DW-1:0] out_en, src, force_in, tst_in, tst_out;

  always_comb begin
    out_en   = '0;
    src      = '0;
    force_in = '0;
    tst_in   = '0;
    tst_out  = '0;
    for (int b = 0; b < 4; b++) out_en[4+b] = pwm_en_q[b];
    src[7] = pwm1_i;
    src[6] = pwm1_i;
    src[5] = pwm0_i;
    src[4] = pwm0_i;
    for (int k = 0; k < 3; k++) begin
      out_en[P2+1+k]   = p2_en_q[k];
      force_in[P1+5+k] = trig_en_q[k];
    end
    src[P2+3]      = dcsync_i;
    src[P2+2]      = fsync_i;
    src[P2+1]      = bclk_i;
    force_in[P2+6] = mode_q;
    tst_in[P1+4]   = test_mode_i;
    tst_out[P2+7]  = test_mode_i;
    src[P2+7]      = test_drv_i;
  end

  for (genvar i = 0; i < DW; i++) begin : g_pin
    assign alt_act_o[i] = tst_out[i] | (out_en[i] & ~force_in[i] & ~tst_in[i]);
    assign pin_oe_o[i]  = pin_oe_f(dir_q[i], out_en[i], force_in[i], tst_in[i], tst_out[i]);
    assign pin_do_o[i]  = alt_act_o[i] ? src[i] : dat_q[i];
    assign pin_alt_o[i] = alt_act_o[i] & src[i];
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int PW    = 8,
  parameter int NPORT = 3,
  localparam int DW   = PW * NPORT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [DW-1:0] pin_i,
  output logic [DW-1:0] pin_oe_o,
  output logic [DW-1:0] pin_do_o,
  output logic [DW-1:0] pin_alt_o,
  input  logic          pwm0_i,
  input  logic          pwm1_i,
  input  logic          dcsync_i,
  input  logic          fsync_i,
  input  logic          bclk_i,
  input  logic          test_mode_i,
  input  logic          test_drv_i,
  output logic [2:0]    timer_trig_o,
  output logic          mtc_o,
  output logic          test_sel_o
);
  logic [DW-1:0] dir_q, dat_q, sync_w, alt_act_w;
  logic [3:0]    pwm_en_q;
  logic [2:0]    trig_en_q, p2_en_q;
  logic          mode_q, srst_w;

  gpio_regs #(.PW(PW), .NPORT(NPORT)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dir_q(dir_q), .dat_q(dat_q), .pwm_en_q(pwm_en_q), .trig_en_q(trig_en_q),
    .p2_en_q(p2_en_q), .mode_q(mode_q), .srst_o(srst_w)
  );

  gpio_sync #(.W(DW)) i_sync (
    .clk(clk), .rst_n(rst_n), .clr(srst_w), .d(pin_i), .q(sync_w)
  );

  gpio_pinmux #(.PW(PW), .NPORT(NPORT)) i_mux (
    .dir_q(dir_q), .dat_q(dat_q), .pwm_en_q(pwm_en_q), .trig_en_q(trig_en_q),
    .p2_en_q(p2_en_q), .mode_q(mode_q), .test_mode_i(test_mode_i),
    .test_drv_i(test_drv_i), .pwm0_i(pwm0_i), .pwm1_i(pwm1_i),
    .dcsync_i(dcsync_i), .fsync_i(fsync_i), .bclk_i(bclk_i),
    .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o), .pin_alt_o(pin_alt_o),
    .alt_act_o(alt_act_w)
  );

  for (genvar k = 0; k < 3; k++) begin : g_trig
    assign timer_trig_o[k] = trig_en_q[k] & sync_w[PW+5+k];
  end
  assign mtc_o      = mode_q & sync_w[2*PW+6];
  assign test_sel_o = test_mode_i & sync_w[PW+4];

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (addr == A_DIR0 + 4'(p)) rdata = dir_q[p*PW +: PW];
      if (addr == A_DAT0 + 4'(p))
        for (int b = 0; b < PW; b++)
          rdata[b] = read_bit_f(pin_oe_o[p*PW+b], dat_q[p*PW+b], sync_w[p*PW+b]);
    end
    if (addr == A_ALTA) rdata[7:4] = pwm_en_q;
    if (addr == A_ALTB) begin
      rdata[7:5] = trig_en_q;
      rdata[3:1] = p2_en_q;
    end
    if (addr == A_MODE) rdata[0] = mode_q;
  end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int PW    = 8,
  parameter int NPORT = 3,
  localparam int DW   = PW * NPORT
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst_w,
  input logic [DW-1:0] pin_i,
  input logic [DW-1:0] sync_w,
  input logic [DW-1:0] pin_oe_o,
  input logic [DW-1:0] pin_do_o,
  input logic [DW-1:0] pin_alt_o,
  input logic [3:0]    pwm_en_q,
  input logic [2:0]    trig_en_q,
  input logic          mode_q,
  input logic          test_mode_i,
  input logic          test_drv_i,
  input logic          pwm1_i,
  input logic [2:0]    timer_trig_o
);
  localparam logic [DW-1:0] TST_OUT_MASK = DW'(1) << (2*PW+7);

  logic [1:0] since_clr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_clr <= '0;
    else if (srst_w) since_clr <= '0;
    else if (since_clr != 2'd2) since_clr <= since_clr + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_clr == 2'd2) |-> (sync_w == $past(pin_i, 2))); // R12
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_w |=> ((pin_oe_o & ~TST_OUT_MASK) == '0)); // R9
  AST_PWM_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en_q[3] |-> (pin_oe_o[7] && (pin_do_o[7] == pwm1_i))); // R4
  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((timer_trig_o & ~trig_en_q) == 3'b000)); // R5
  AST_TRIG_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    trig_en_q[0] |-> !pin_oe_o[PW+5]); // R5
  AST_MTC_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !pin_oe_o[2*PW+6]); // R7
  AST_TEST_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_i |-> (pin_oe_o[2*PW+7] && !pin_oe_o[PW+4] && (pin_do_o[2*PW+7] == test_drv_i))); // R8
  AST_ALT_ONLY_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_alt_o & ~pin_oe_o) == '0)); // R11
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.PW(PW), .NPORT(NPORT)) i_chk (
  .clk(clk), .rst_n(rst_n), .srst_w(srst_w), .pin_i(pin_i), .sync_w(sync_w),
  .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o), .pin_alt_o(pin_alt_o),
  .pwm_en_q(pwm_en_q), .trig_en_q(trig_en_q), .mode_q(mode_q),
  .test_mode_i(test_mode_i), .test_drv_i(test_drv_i), .pwm1_i(pwm1_i),
  .timer_trig_o(timer_trig_o)
);

// File: tb/test_gpio_ctrl.sv
module test_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] pin_i = '0;
  logic [23:0] pin_oe_o, pin_do_o, pin_alt_o;
  logic        pwm0_i = 0, pwm1_i = 0, dcsync_i = 0, fsync_i = 0, bclk_i = 0;
  logic        test_mode_i = 0, test_drv_i = 0;
  logic [2:0]  timer_trig_o;
  logic        mtc_o, test_sel_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_ctrl i_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_i(pin_i), .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o),
    .pin_alt_o(pin_alt_o), .pwm0_i(pwm0_i), .pwm1_i(pwm1_i),
    .dcsync_i(dcsync_i), .fsync_i(fsync_i), .bclk_i(bclk_i),
    .test_mode_i(test_mode_i), .test_drv_i(test_drv_i),
    .timer_trig_o(timer_trig_o), .mtc_o(mtc_o), .test_sel_o(test_sel_o)
  );

  // {direction, data, pad} for port 0
  localparam logic [23:0] VEC [6] = '{
    24'h00_FF_A5, 24'hFF_3C_00, 24'hF0_AA_55,
    24'h0F_12_F0, 24'h55_FF_00, 24'hAA_00_FF
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [7:0] exp);
    addr = a;
    #1;
    check(req, 32'(rdata), 32'(exp));
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 / R10 reset state and empty address
    for (int a = 0; a < 10; a++) rd("R1", 4'(a), 8'h00);
    check("R1 oe", 32'(pin_oe_o), 0);
    check("R1 do", 32'(pin_do_o), 0);
    check("R1 side outputs", {29'd0, timer_trig_o}, 0);
    rd("R10 unused addr", 4'd12, 8'h00);

    // R2 / R3 table of port 0 settings
    foreach (VEC[v]) begin
      wr(4'd0, VEC[v][23:16]);
      wr(4'd3, VEC[v][15:8]);
      pin_i[7:0] = VEC[v][7:0];
      tick(2);
      check("R2 oe", 32'(pin_oe_o[7:0]), 32'(VEC[v][23:16]));
      check("R2 do", 32'(pin_do_o[7:0]), 32'(VEC[v][15:8]));
      rd("R3 readback", 4'd3,
         (VEC[v][23:16] & VEC[v][15:8]) | (~VEC[v][23:16] & VEC[v][7:0]));
    end
    rd("R10 dir0", 4'd0, 8'hAA);

    // R12 exact two-cycle latency on port 1 inputs
    pin_i[15:8] = 8'h00;
    tick(3);
    pin_i[15:8] = 8'h3C;
    tick(1);
    rd("R12 one cycle", 4'd4, 8'h00);
    tick(1);
    rd("R12 two cycles", 4'd4, 8'h3C);

    // R9 soft reset clears registers and synchronizers
    pin_i = 24'hFFFFFF;
    wr(4'd1, 8'hFF);
    wr(4'd7, 8'hEE);
    rd("R9 bit0 reads 0", 4'd7, 8'hEE);
    tick(2);
    wr(4'd7, 8'h01);
    rd("R9 alt cleared", 4'd7, 8'h00);
    rd("R9 dir cleared", 4'd1, 8'h00);
    rd("R9 sync cleared", 4'd5, 8'h00);
    check("R9 oe", 32'(pin_oe_o), 0);
    pin_i = '0;

    // R4 PWM on port 0, R11 alt output
    pwm1_i = 1'b1; pwm0_i = 1'b0;
    wr(4'd3, 8'hFF);
    wr(4'd6, 8'hFF);
    rd("R10 alt0 reserved", 4'd6, 8'hF0);
    check("R4 oe", 32'(pin_oe_o[7:0]), 32'h F0);
    check("R4 do", 32'(pin_do_o[7:4]), 32'hC);
    check("R11 alt", 32'(pin_alt_o), 32'h0000C0);
    pwm0_i = 1'b1; #1;
    check("R4 pwm0", 32'(pin_do_o[5:4]), 32'h3);

    // R5 forced inputs on port 1 feed timers
    wr(4'd1, 8'hFF);
    wr(4'd4, 8'h00);
    wr(4'd7, 8'hF0);
    rd("R10 alt1 reserved", 4'd7, 8'hE0);
    pin_i[15:8] = 8'hA0;
    tick(2);
    check("R5 oe", 32'(pin_oe_o[15:8]), 32'h1F);
    check("R5 trig", 32'(timer_trig_o), 32'h5);
    rd("R5 readback", 4'd4, 8'hA0);

    // R6 port 2 clock/sync outputs
    dcsync_i = 1'b1; fsync_i = 1'b0; bclk_i = 1'b1;
    wr(4'd7, 8'h0E);
    #1;
    check("R6 oe", 32'(pin_oe_o[19:16]), 32'hE);
    check("R6 do", 32'(pin_do_o[19:17]), 32'h5);
    check("R11 alt p2", 32'(pin_alt_o[23:16]), 32'h0A);
    check("R5 trig off", 32'(timer_trig_o), 0);

    // R7 master clock input
    wr(4'd2, 8'hFF);
    wr(4'd8, 8'hFF);
    rd("R10 mode reserved", 4'd8, 8'h01);
    pin_i[22] = 1'b1;
    tick(2);
    check("R7 oe", 32'(pin_oe_o[22]), 0);
    check("R7 mtc", 32'(mtc_o), 1);

    // R8 test remap overrides directions
    test_mode_i = 1'b1; test_drv_i = 1'b1;
    wr(4'd8, 8'h00);
    pin_i[12] = 1'b1;
    tick(2);
    check("R8 p1.4 input", 32'(pin_oe_o[12]), 0);
    check("R8 sel", 32'(test_sel_o), 1);
    check("R8 p2.7 drive", 32'({pin_oe_o[23], pin_do_o[23], pin_alt_o[23]}), 32'h7);
    test_drv_i = 1'b0; #1;
    check("R8 drive low", 32'(pin_do_o[23]), 0);
    test_mode_i = 1'b0; #1;
    check("R8 off", 32'({pin_oe_o[23], test_sel_o}), 32'h2);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule